// File: doc/BRIEF.md
# SPI Slave Command Receive Buffer

This block receives display commands from a host over SPI and holds them for a downstream command parser. The link runs in mode 0: the clock idles low, the block samples MOSI on each rising SCK edge and updates MISO on each falling edge. Bytes are eight bits long, sent MSB first, and an active-low select frames them. SCK, MOSI and select are brought into the system clock domain by two-flop synchronizers. Edges are found by comparing successive synchronized samples, so the system clock must run many times faster than SCK. A frame may carry any number of bytes. Raising select clears a partly received byte.

Each byte that arrives goes into a 186-entry receive FIFO. On every byte exchange the block sends back the number of bytes held in the FIFO. The host can use this count for flow control. The parser reads the FIFO ahead of its release point: it steps a peek pointer byte by byte, and once it holds a whole command it gives a commit pulse with the command length. Only the commit lowers the stored count. The count reported to the host therefore includes every byte of a command the parser has not finished.

After reset there is an initialization window, its length set by a cycle-count parameter. During this window the block drops every byte it receives and returns zero on MISO. If a byte arrives while the FIFO is full, the byte is lost and a sticky overflow flag is set.

Top module: `spi_cmd_fifo`

## Requirements
- R1: A byte is assembled MSB first from MOSI, sampled on eight rising SCK edges while select is low. Stored bytes reach the parser in the order they arrived, including several bytes sent inside one select frame.
- R2: During each byte the block returns, MSB first on MISO, the FIFO occupancy at the start of that byte. The start of a byte is the select falling edge or the falling SCK edge that follows the previous byte. The count includes the byte that came just before, and it saturates at 255.
- R3: Raising select before eight bits have arrived throws away the partial byte and restarts the bit count. Nothing is stored, and the next full byte is received intact.
- R4: The FIFO holds up to DEPTH (default 186) bytes. Occupancy rises by one for each byte stored and never goes above DEPTH.
- R5: Stepping the peek pointer does not lower the occupancy. A commit pulse lowers it by exactly commit_len, so an unfinished command stays in the reported count.
- R6: A byte that completes while the FIFO holds DEPTH bytes is dropped and sets overflow. Overflow stays high until reset, and the FIFO contents and count do not change.
- R7: init_busy is high for exactly INIT_CYCLES clock cycles after reset is released. During that window received bytes are discarded and MISO stays low.
- R8: After reset: init_busy is 1, overflow is 0, peek_avail is 0 and MISO is 0. peek_avail is high while some stored bytes have not yet been stepped over, peek_data shows the byte at the peek pointer, and a peek_step advances the pointer by one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from the host, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_csn | input | 1 | Active-low select, frames bytes |
| spi_miso | output | 1 | Serial occupancy reply to the host |
| init_busy | output | 1 | High during the power-up window |
| overflow | output | 1 | Sticky flag: a byte was lost because the FIFO was full |
| peek_avail | output | 1 | A stored byte has not yet been stepped over |
| peek_data | output | 8 | Byte at the peek pointer |
| peek_step | input | 1 | Advance the peek pointer by one byte |
| commit_valid | input | 1 | Release a complete command |
| commit_len | input | $clog2(DEPTH+1) | Number of bytes released by commit_valid |

## Verification
The bench checks that replies keep counting up across a multi-byte frame. A design that loaded the reply only at the select edge would repeat the first count for every byte. It sends a byte with the parser still holding three bytes that it has peeked but not committed. A design that lowered the count on each peek step would reply zero here instead of three. It sends a three-bit fragment and closes the frame, then sends a full byte. A bit counter that select does not clear would shift that byte by three bits, and a design that stored the fragment would report one extra byte. It fills the FIFO to exactly 186 bytes and then sends two more. Replies stopping at 185, a stored extra byte, or an overflow flag that clears on its own are all caught, as are replies or stored data during the initialization window.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef logic [7:0] byte_t;

  // Clamp an occupancy value to one reply byte.
  function automatic byte_t sat_byte(input int unsigned v);
    return (v > 255) ? 8'hFF : byte_t'(v);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= din;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sck_s,
  input  logic  mosi_s,
  input  logic  csn_s,
  input  byte_t reply,
  output logic  byte_valid,
  output byte_t byte_data,
  output logic  miso
);
  logic       sck_d;
  logic       csn_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  byte_t      tx_sh;
  logic       rise, fall, sel_fall;

  always_comb begin
    rise     = sck_s & ~sck_d & ~csn_s;
    fall     = ~sck_s & sck_d & ~csn_s;
    sel_fall = ~csn_s & csn_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= 1'b0;
      csn_d      <= 1'b1;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      sck_d      <= sck_s;
      csn_d      <= csn_s;
      byte_valid <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_valid <= 1'b1;
          byte_data  <= {rx_sh, mosi_s};
        end
      end
      if (sel_fall) begin
        tx_sh <= reply;
      end else if (fall) begin
        if (bit_cnt == 3'd0) tx_sh <= reply;
        else                 tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[7];
endmodule

// File: rtl/spi_init_timer.sv
module spi_init_timer #(
  parameter int unsigned INIT_CYCLES = 5_000_000,
  localparam int TW = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic busy
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == TW'(INIT_CYCLES - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 186,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  byte_t         wr_data,
  input  logic          peek_step,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  output byte_t         peek_data,
  output logic          peek_avail,
  output logic [CW-1:0] level,
  output logic          full
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, peek_ptr, peek_ptr_nx;
  logic [CW-1:0] peek_cnt;
  logic          do_wr, take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full        = (level == CW'(DEPTH));
    do_wr       = wr_en & ~full;
    take        = peek_step & (peek_cnt != '0);
    peek_ptr_nx = take ? bump(peek_ptr) : peek_ptr;
    peek_avail  = (peek_cnt != '0);
  end

  // Storage and registered read port, with bypass of a same-cycle write.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
    if (do_wr && (wr_ptr == peek_ptr_nx)) peek_data <= wr_data;
    else                                  peek_data <= mem[peek_ptr_nx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      peek_ptr <= '0;
      peek_cnt <= '0;
      level    <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      peek_ptr <= peek_ptr_nx;
      peek_cnt <= peek_cnt + CW'(do_wr) - CW'(take);
      level    <= level + CW'(do_wr) - (commit ? commit_len : CW'(0));
    end
  end
endmodule

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 186,
  parameter int unsigned INIT_CYCLES = 5_000_000,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  input  logic             spi_csn,
  output logic             spi_miso,
  output logic             init_busy,
  output logic             overflow,
  output logic             peek_avail,
  output logic [7:0]       peek_data,
  input  logic             peek_step,
  input  logic             commit_valid,
  input  logic [LEN_W-1:0] commit_len
);
  logic [2:0]       pins_s;
  logic             byte_valid, full, wr_en;
  byte_t            byte_data, reply;
  logic [LEN_W-1:0] level;

  spi_pin_sync #(.W(3), .RST_VAL(3'b100)) sync_i (
    .clk (clk),
    .rst (rst),
    .din ({spi_csn, spi_mosi, spi_sck}),
    .q   (pins_s)
  );

  spi_init_timer #(.INIT_CYCLES(INIT_CYCLES)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .busy (init_busy)
  );

  always_comb begin
    reply = init_busy ? 8'h00 : sat_byte(int'(level));
    wr_en = byte_valid & ~init_busy;
  end

  spi_byte_engine engine_i (
    .clk        (clk),
    .rst        (rst),
    .sck_s      (pins_s[0]),
    .mosi_s     (pins_s[1]),
    .csn_s      (pins_s[2]),
    .reply      (reply),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .miso       (spi_miso)
  );

  cmd_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (byte_data),
    .peek_step  (peek_step),
    .commit     (commit_valid),
    .commit_len (commit_len),
    .peek_data  (peek_data),
    .peek_avail (peek_avail),
    .level      (level),
    .full       (full)
  );

  always_ff @(posedge clk) begin
    if (rst)                  overflow <= 1'b0;
    else if (wr_en && full)   overflow <= 1'b1;
  end
endmodule

// File: rtl/spi_cmd_fifo_chk.sv
module spi_cmd_fifo_chk #(
  parameter int DEPTH = 186,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_miso,
  input logic             init_busy,
  input logic             overflow,
  input logic             commit_valid,
  input logic [LEN_W-1:0] level
);
  // R6: once set, overflow holds until reset
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R7: the reply line stays low throughout the init window
  a_r7_miso_quiet: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !spi_miso);

  // R7: the init window ends once and does not come back
  a_r7_busy_once: assert property (@(posedge clk) disable iff (rst)
    !init_busy |=> !init_busy);

  // R4: occupancy never exceeds the depth
  a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  // R4: occupancy grows by at most one byte per cycle
  a_r4_level_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int'(level) <= int'($past(level)) + 1);

  // R5: without a commit the occupancy never falls
  a_r5_no_drop: assert property (@(posedge clk) disable iff (rst)
    !commit_valid |=> int'(level) >= int'($past(level)));
endmodule

bind spi_cmd_fifo spi_cmd_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .spi_miso     (spi_miso),
  .init_busy    (init_busy),
  .overflow     (overflow),
  .commit_valid (commit_valid),
  .level        (level)
);

// File: tb/spi_cmd_fifo_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_fifo_tb_top;
  localparam int DEPTH = 186;
  localparam int INIT  = 400;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int HALF  = 12;
  localparam int GAP   = 30;

  logic clk = 0;
  logic rst = 1;
  logic sck = 0, mosi = 0, csn = 1;
  logic miso, init_busy, overflow, peek_avail;
  logic [7:0] peek_data;
  logic peek_step, commit_valid;
  logic [LW-1:0] commit_len;

  int checks = 0, failures = 0;
  int exp_count = 0;
  int cyc = 0;
  int cmd_len = 4;
  int got = 0;
  bit parser_en = 0;
  logic [7:0] q[$];
  logic [7:0] rx;

  always #5 clk = ~clk;

  spi_cmd_fifo #(.DEPTH(DEPTH), .INIT_CYCLES(INIT)) dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_csn(csn),
    .spi_miso(miso), .init_busy(init_busy), .overflow(overflow),
    .peek_avail(peek_avail), .peek_data(peek_data), .peek_step(peek_step),
    .commit_valid(commit_valid), .commit_len(commit_len));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor acting as the command parser.
  always @(negedge clk) begin
    peek_step    = 1'b0;
    commit_valid = 1'b0;
    commit_len   = '0;
    if (rst) begin
      got = 0;
    end else if (parser_en && peek_avail) begin
      if (q.size() == 0) begin
        chk("R4 unexpected stored byte", int'(peek_data), -1);
      end else begin
        chk("R1 byte order and value", int'(peek_data), int'(q[0]));
        void'(q.pop_front());
      end
      peek_step = 1'b1;
      got++;
      if (got == cmd_len) begin
        commit_valid = 1'b1;
        commit_len   = LW'(cmd_len);
        exp_count    = exp_count - cmd_len;
        got          = 0;
      end
    end
  end

  task automatic sel_low();
    csn = 0;
    wait_clk(HALF);
  endtask

  task automatic sel_high();
    wait_clk(HALF);
    csn = 1;
    wait_clk(GAP);
  endtask

  // Exchange one byte; the reply is checked against the model occupancy.
  task automatic xfer(input logic [7:0] d, input bit in_init, input string tag);
    int exp_r;
    logic [7:0] r;
    exp_r = in_init ? 0 : ((exp_count > 255) ? 255 : exp_count);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      wait_clk(HALF);
      sck = 1;
      r[i] = miso;
      if (i == 0 && !in_init) begin
        if (exp_count < DEPTH) begin
          q.push_back(d);
          exp_count++;
        end
      end
      wait_clk(HALF);
      sck = 0;
    end
    rx = r;
    chk(tag, int'(r), exp_r);
  endtask

  task automatic frame1(input logic [7:0] d, input bit in_init, input string tag);
    sel_low();
    xfer(d, in_init, tag);
    sel_high();
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    wait_clk(10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 0;
    wait_clk(2);
    // R8 reset state
    chk("R8 init_busy after reset", int'(init_busy), 1);
    chk("R8 overflow after reset", int'(overflow), 0);
    chk("R8 peek_avail after reset", int'(peek_avail), 0);
    chk("R8 miso after reset", int'(miso), 0);

    // R7 byte during the init window
    frame1(8'hA5, 1, "R7 reply during init");
    chk("R7 init byte discarded", int'(peek_avail), 0);
    while (cyc < INIT - 1) @(negedge clk);
    chk("R7 busy at last init cycle", int'(init_busy), 1);
    wait_clk(2);
    chk("R7 busy cleared after window", int'(init_busy), 0);
    wait_clk(5);

    // R2 replies on single-byte frames
    frame1(8'h11, 0, "R2 reply 0");
    frame1(8'h22, 0, "R2 reply 1");
    frame1(8'h83, 0, "R2 reply 2");
    frame1(8'h4C, 0, "R2 reply 3");
    // R2 and R1 several bytes in one frame
    sel_low();
    xfer(8'hF0, 0, "R2 frame byte0 reply");
    xfer(8'h0F, 0, "R2 frame byte1 reply");
    xfer(8'h5A, 0, "R2 frame byte2 reply");
    sel_high();
    // R3 partial byte cut off by select
    sel_low();
    for (int i = 0; i < 3; i++) begin
      mosi = 1;
      wait_clk(HALF);
      sck = 1;
      wait_clk(HALF);
      sck = 0;
    end
    sel_high();
    frame1(8'hC3, 0, "R3 reply after aborted fragment");

    // R5 whole-command release, commands of 4 bytes
    cmd_len = 4;
    parser_en = 1;
    drain();
    frame1(8'h99, 0, "R5 reply after commits");
    frame1(8'h98, 0, "R5 reply counts peeked byte");
    frame1(8'h97, 0, "R5 reply counts two peeked");
    frame1(8'h96, 0, "R5 reply counts three peeked");
    drain();
    frame1(8'h95, 0, "R5 reply after command commit");
    frame1(8'h94, 0, "R5 reply partial command");
    frame1(8'h93, 0, "R5 reply partial command 2");
    frame1(8'h92, 0, "R5 reply partial command 3");
    drain();
    parser_en = 0;
    chk("R5 model empty", exp_count, 0);

    // R4 fill to depth, R6 overflow
    for (int i = 0; i < DEPTH; i++) frame1(8'(i * 7 + 3), 0, "R4 fill reply");
    chk("R6 no overflow at exactly full", int'(overflow), 0);
    frame1(8'hEE, 0, "R6 reply when full");
    wait_clk(5);
    chk("R6 overflow set", int'(overflow), 1);
    frame1(8'hED, 0, "R6 dropped byte not counted");
    chk("R6 overflow stays", int'(overflow), 1);

    // drain in 2-byte commands; dropped bytes must not appear
    cmd_len = 2;
    parser_en = 1;
    drain();
    wait_clk(5);
    chk("R6 no extra byte after drain", int'(peek_avail), 0);
    frame1(8'h5F, 0, "R5 reply after full drain");
    drain();
    chk("R6 overflow sticky after drain", int'(overflow), 1);
    parser_en = 0;

    // R6 reset clears the flag
    rst = 1;
    wait_clk(3);
    rst = 0;
    q.delete();
    exp_count = 0;
    wait_clk(2);
    chk("R6 overflow cleared by reset", int'(overflow), 0);
    chk("R8 busy again after reset", int'(init_busy), 1);
    chk("R8 peek_avail after second reset", int'(peek_avail), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule